// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits next to a 32-bit core and decides whether each store-conditional succeeds. When the core issues a load-reserved, the monitor records the effective address and arms a single reservation. When the core issues a store-conditional, the monitor compares that address with the recorded one. It returns a pass or fail verdict combinationally in the same cycle, and then drops the reservation whatever the verdict.

Several events cancel the reservation. The core reports a trap (an exception or an interrupt being taken) and a trap return. A separate hold input, when driven low in a cycle with no store-conditional, clears the reservation. Addresses are compared at granule resolution: the granule is a power-of-two byte count, and the low address bits inside it are ignored. A registered observation output shows the recorded address while a reservation is held and reads all-ones otherwise.

The monitor has two named states, EMPTY and ARMED. Each cycle an arbiter reduces the requests to one action. KILL is chosen when a trap or a trap return is present. CHECK is chosen for a store-conditional. DROP is chosen when hold is low with no store-conditional. ARM is chosen for a load-reserved. NONE is chosen otherwise. The actions are listed here in falling priority. The state transitions are:

- EMPTY to ARMED on ARM.
- ARMED to ARMED on ARM, which replaces the address.
- ARMED to EMPTY on CHECK, KILL or DROP.
- EMPTY stays EMPTY on every action other than ARM.

Top module: `resv_monitor`

## Requirements
- R1: After reset the observation output reads 0xFFFFFFFF and a store-conditional fails.
- R2: A load-reserved with no competing event arms the reservation; from the next cycle the observation output shows its full address.
- R3: A store-conditional whose address matches the recorded one at granule resolution drives sc_pass high in the same cycle it is requested.
- R4: A store-conditional whose address falls in a different granule fails.
- R5: After any store-conditional, passing or failing, the observation output reads 0xFFFFFFFF and a following store-conditional fails.
- R6: A store-conditional with no reservation held always fails.
- R7: A load-reserved while a reservation is held replaces the recorded address.
- R8: hold_ok low in a cycle without a store-conditional clears the reservation. In a cycle with a store-conditional, hold_ok has no effect on the verdict.
- R9: trap_evt clears the reservation, and a store-conditional in the same cycle as trap_evt fails.
- R10: xret_evt clears the reservation, and a store-conditional in the same cycle as xret_evt fails.
- R11: The comparison ignores the low log2(GRAIN_BYTES) address bits. With an 8-byte granule, 0x40 and 0x47 match, while 0x40 and 0x48 do not.
- R12: When a load-reserved and a store-conditional arrive together, the store-conditional is judged against the old reservation. The load-reserved is dropped and the monitor ends EMPTY.
- R13: A load-reserved in a cycle with hold_ok low and no store-conditional is not recorded; the monitor ends EMPTY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_req | input | 1 | Load-reserved strobe |
| lr_addr | input | 32 | Load-reserved effective address |
| sc_req | input | 1 | Store-conditional strobe |
| sc_addr | input | 32 | Store-conditional effective address |
| hold_ok | input | 1 | Low outside a store-conditional cancels the reservation |
| trap_evt | input | 1 | Exception or interrupt taken |
| xret_evt | input | 1 | Trap-return executed |
| sc_pass | output | 1 | Combinational store-conditional verdict, 1 = success |
| resv_obs | output | 32 | Recorded address when ARMED, all-ones when EMPTY |

## Verification
The bench targets the points where priority decides the outcome. If a trap arrives alongside a store-conditional, a monitor that ranked the store above the trap would report a pass. If a load-reserved arrives together with a store-conditional, a design that let the load win would stay ARMED. A hold drop with a store present would, if wrongly decoded, flip a valid pass to a fail. Granule edges, at offsets 7 and 8 with an 8-byte granule, catch a mask that is off by one bit. A mismatched store that does not clear the reservation shows up as a stale address on the observation output.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [0:0] {
        RS_EMPTY = 1'b0,
        RS_ARMED = 1'b1
    } resv_state_e;

    typedef enum logic [2:0] {
        ACT_NONE  = 3'd0,
        ACT_ARM   = 3'd1,
        ACT_CHECK = 3'd2,
        ACT_DROP  = 3'd3,
        ACT_KILL  = 3'd4
    } resv_act_e;

    typedef struct packed {
        logic lr;
        logic sc;
        logic hold;
        logic trap;
        logic xret;
    } resv_evt_t;

endpackage

// File: rtl/resv_event_arb.sv
module resv_event_arb
    import resv_pkg::*;
(
    input  resv_evt_t evt,
    output resv_act_e act
);

    // Priority: trap/return > store-conditional > hold drop > load-reserved
    always_comb begin
        act = ACT_NONE;
        if (evt.trap || evt.xret) begin
            act = ACT_KILL;
        end else if (evt.sc) begin
            act = ACT_CHECK;
        end else if (!evt.hold) begin
            act = ACT_DROP;
        end else if (evt.lr) begin
            act = ACT_ARM;
        end
    end

endmodule

// File: rtl/resv_addr_cmp.sv
module resv_addr_cmp #(
    parameter int ADDR_W    = 32,
    parameter int GRAIN_LG2 = 0
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_granule
);

    logic [ADDR_W-1:0] diff;
    assign diff = addr_a ^ addr_b;

    generate
        if (GRAIN_LG2 == 0) begin : g_exact
            assign same_granule = (diff == '0);
        end else begin : g_masked
            localparam logic [ADDR_W-1:0] KEEP_MASK = ~((ADDR_W'(1) << GRAIN_LG2) - ADDR_W'(1));
            assign same_granule = ((diff & KEEP_MASK) == '0);
        end
    endgenerate

endmodule

// File: rtl/resv_fsm.sv
module resv_fsm
    import resv_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  resv_act_e         act,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic              same_granule,
    output logic [ADDR_W-1:0] held_addr,
    output logic              armed,
    output logic              sc_pass,
    output logic [ADDR_W-1:0] obs_q
);

    localparam logic [ADDR_W-1:0] NO_RESV = '1;

    resv_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_EMPTY;
            addr_q  <= '0;
            obs_q   <= NO_RESV;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            obs_q   <= (state_d == RS_ARMED) ? addr_d : NO_RESV;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            RS_EMPTY: begin
                if (act == ACT_ARM) begin
                    state_d = RS_ARMED;
                    addr_d  = new_addr;
                end
            end
            RS_ARMED: begin
                if (act == ACT_ARM) begin
                    addr_d = new_addr;
                end else if (act == ACT_CHECK || act == ACT_KILL || act == ACT_DROP) begin
                    state_d = RS_EMPTY;
                end
            end
            default: state_d = RS_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        sc_pass = 1'b0;
        unique case (state_q)
            RS_EMPTY: sc_pass = 1'b0;
            RS_ARMED: sc_pass = (act == ACT_CHECK) && same_granule;
            default:  sc_pass = 1'b0;
        endcase
    end

    assign held_addr = addr_q;
    assign armed     = (state_q == RS_ARMED);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int GRAIN_BYTES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_req,
    input  logic [ADDR_W-1:0] lr_addr,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              hold_ok,
    input  logic              trap_evt,
    input  logic              xret_evt,
    output logic              sc_pass,
    output logic [ADDR_W-1:0] resv_obs
);

    localparam int GRAIN_LG2 = $clog2(GRAIN_BYTES);

    resv_evt_t         evt;
    resv_act_e         act;
    logic [ADDR_W-1:0] held_addr;
    logic              same_granule;
    logic              armed_w;

    assign evt = '{lr: lr_req, sc: sc_req, hold: hold_ok, trap: trap_evt, xret: xret_evt};

    resv_event_arb u_arb (
        .evt (evt),
        .act (act)
    );

    resv_addr_cmp #(
        .ADDR_W    (ADDR_W),
        .GRAIN_LG2 (GRAIN_LG2)
    ) u_cmp (
        .addr_a       (sc_addr),
        .addr_b       (held_addr),
        .same_granule (same_granule)
    );

    resv_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .act          (act),
        .new_addr     (lr_addr),
        .same_granule (same_granule),
        .held_addr    (held_addr),
        .armed        (armed_w),
        .sc_pass      (sc_pass),
        .obs_q        (resv_obs)
    );

endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int ADDR_W    = 32,
    parameter int GRAIN_LG2 = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lr_req,
    input logic [ADDR_W-1:0] lr_addr,
    input logic              sc_req,
    input logic [ADDR_W-1:0] sc_addr,
    input logic              hold_ok,
    input logic              trap_evt,
    input logic              xret_evt,
    input logic              sc_pass,
    input logic [ADDR_W-1:0] resv_obs,
    input logic              armed
);

    AST_PASS_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> armed); // R6
    AST_PASS_NEEDS_SC: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> sc_req); // R3
    AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> (resv_obs == '1)); // R5
    AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_evt |=> (resv_obs == '1)); // R9
    AST_TRAP_BLOCKS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_evt |-> !sc_pass); // R9
    AST_XRET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        xret_evt |=> (resv_obs == '1)); // R10
    AST_XRET_BLOCKS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        xret_evt |-> !sc_pass); // R10
    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_ok && !sc_req) |=> (resv_obs == '1)); // R8
    AST_LR_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_req && !sc_req && hold_ok && !trap_evt && !xret_evt) |=> (resv_obs == $past(lr_addr))); // R2
    AST_PASS_SAME_GRANULE: assert property (@(posedge clk) disable iff (!rst_n)
        sc_pass |-> (((sc_addr ^ resv_obs) >> GRAIN_LG2) == '0)); // R11

endmodule

bind resv_monitor resv_monitor_chk #(
    .ADDR_W    (ADDR_W),
    .GRAIN_LG2 (GRAIN_LG2)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lr_req   (lr_req),
    .lr_addr  (lr_addr),
    .sc_req   (sc_req),
    .sc_addr  (sc_addr),
    .hold_ok  (hold_ok),
    .trap_evt (trap_evt),
    .xret_evt (xret_evt),
    .sc_pass  (sc_pass),
    .resv_obs (resv_obs),
    .armed    (armed_w)
);

// File: tb/resv_monitor_tb_top.sv
module resv_monitor_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lr_req = 1'b0;
    logic [31:0] lr_addr = '0;
    logic        sc_req = 1'b0;
    logic [31:0] sc_addr = '0;
    logic        hold_ok = 1'b1;
    logic        trap_evt = 1'b0;
    logic        xret_evt = 1'b0;
    logic        sc_pass;
    logic [31:0] resv_obs;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    bit          m_held = 0;
    logic [31:0] m_addr = '0;

    always #4 clk = ~clk;

    resv_monitor #(.ADDR_W(32), .GRAIN_BYTES(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lr_req(lr_req), .lr_addr(lr_addr),
        .sc_req(sc_req), .sc_addr(sc_addr),
        .hold_ok(hold_ok), .trap_evt(trap_evt), .xret_evt(xret_evt),
        .sc_pass(sc_pass), .resv_obs(resv_obs)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic lr, input logic [31:0] la, input logic sc, input logic [31:0] sa,
                        input logic hold, input logic trap, input logic xret, input string tag);
        logic exp_pass;
        @(negedge clk);
        lr_req = lr; lr_addr = la; sc_req = sc; sc_addr = sa;
        hold_ok = hold; trap_evt = trap; xret_evt = xret;
        #1;
        exp_pass = sc && m_held && !trap && !xret && ((sa >> 3) == (m_addr >> 3));
        chk(tag, "sc_pass", {31'b0, sc_pass}, {31'b0, exp_pass});
        @(posedge clk);
        if (trap || xret)   m_held = 0;
        else if (sc)        m_held = 0;
        else if (!hold)     m_held = 0;
        else if (lr) begin  m_held = 1; m_addr = la; end
        #2;
        chk(tag, "resv_obs", resv_obs, m_held ? m_addr : 32'hFFFF_FFFF);
        lr_req = 0; sc_req = 0; hold_ok = 1; trap_evt = 0; xret_evt = 0;
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "obs in reset", resv_obs, 32'hFFFF_FFFF);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 1, 32'h0, 1, 0, 0, "R1");
        step(0, 0, 1, 32'h100, 1, 0, 0, "R6");
        step(1, 32'h1000, 0, 0, 1, 0, 0, "R2");
        step(0, 0, 1, 32'h1000, 1, 0, 0, "R3");
        step(0, 0, 1, 32'h1000, 1, 0, 0, "R5");
        step(1, 32'h2000, 0, 0, 1, 0, 0, "R2");
        step(0, 0, 1, 32'h3000, 1, 0, 0, "R4");
        step(0, 0, 1, 32'h2000, 1, 0, 0, "R5");
        step(1, 32'h40, 0, 0, 1, 0, 0, "R7");
        step(1, 32'h80, 0, 0, 1, 0, 0, "R7");
        step(0, 0, 1, 32'h40, 1, 0, 0, "R7");
        step(1, 32'h40, 0, 0, 1, 0, 0, "R11");
        step(0, 0, 1, 32'h47, 1, 0, 0, "R11");
        step(1, 32'h40, 0, 0, 1, 0, 0, "R11");
        step(0, 0, 1, 32'h48, 1, 0, 0, "R11");
        step(1, 32'h500, 0, 0, 1, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 1, 32'h500, 1, 0, 0, "R8");
        step(1, 32'h600, 0, 0, 1, 0, 0, "R8");
        step(0, 0, 1, 32'h600, 0, 0, 0, "R8");
        step(1, 32'h700, 0, 0, 1, 0, 0, "R9");
        step(0, 0, 0, 0, 1, 1, 0, "R9");
        step(1, 32'h700, 0, 0, 1, 0, 0, "R9");
        step(0, 0, 1, 32'h700, 1, 1, 0, "R9");
        step(1, 32'h800, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 1, 0, 1, "R10");
        step(1, 32'h800, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 1, 32'h800, 1, 0, 1, "R10");
        step(1, 32'h900, 0, 0, 1, 0, 0, "R12");
        step(1, 32'hA00, 1, 32'h900, 1, 0, 0, "R12");
        step(0, 0, 1, 32'hA00, 1, 0, 0, "R12");
        step(1, 32'hB00, 0, 0, 0, 0, 0, "R13");
        step(0, 0, 1, 32'hB00, 1, 0, 0, "R13");
        step(1, 32'hFFFF_FFF8, 0, 0, 1, 0, 0, "R11");
        step(0, 0, 1, 32'hFFFF_FFFF, 1, 0, 0, "R11");
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], {26'b0, r[9:4]}, r[1] & r[2], {26'b0, r[15:10]},
                 ~(r[16] & r[17] & r[18]), r[19] & r[20] & r[21], r[22] & r[23] & r[24], "R3");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule